// File: doc/BRIEF.md
# Capture, Compare and PWM Unit

A single-channel timing peripheral that sits next to an external 16-bit free-running timer. One 16-bit data register is shared by three behaviours, picked by a 4-bit mode code in the control register. In capture modes the unit copies the timer into the data register when the capture pin shows a selected edge, optionally after a prescaler that counts rising edges. In compare modes it watches for the timer equalling the data register and then toggles, sets or clears an output latch, raises the interrupt flag, or emits a one-cycle special-event strobe that a neighbour uses to reset the timer and start an A/D conversion. In PWM mode it drives a 10-bit-resolution duty waveform.

Software reaches the unit through a byte-wide write port and a combinational read port. Address 0 is control (bits 3:0 mode code, bits 5:4 the two low duty bits, bits 7:6 read as 0), address 1 is the low data byte, address 2 the high data byte. The interrupt flag is sticky and is cleared by pulsing `flagClear`. Mode codes: 0000, 0001, 0011 disabled; 0010 toggle on match; 0100 capture falling edges; 0101 capture rising edges; 0110 capture every 4th rising edge; 0111 capture every 16th rising edge; 1000 init low, high on match; 1001 init high, low on match; 1010 flag only; 1011 special event; 11xx PWM.

Top module: `cap_cmp_pwm`

## Requirements
- R1: After reset all three registers read 0, and `pinOut`, `intFlag` and `specialOut` are 0.
- R2: A control write stores bits 5:4 and 3:0; bits 7:6 always read back as 0 at address 0.
- R3: In mode 0101 each rising edge and in mode 0100 each falling edge of `capPin` (after a two-flop synchroniser) copies `timerVal` into the data register and sets `intFlag`.
- R4: Mode 0110 captures only on every 4th rising edge and mode 0111 only on every 16th; the edge count restarts whenever the mode code changes or the unit is disabled.
- R5: Mode 0010 inverts the output on every compare match (timer equal to the data register, counted once per run of equal values) and sets `intFlag`.
- R6: Mode 1000 drives the output low on entry and high on a match; mode 1001 drives it high on entry and low on a match; both set `intFlag` on a match.
- R7: Mode 1010 sets `intFlag` on a match and leaves the output level unchanged.
- R8: Mode 1011 produces exactly one cycle of `specialOut` per match and sets `intFlag`.
- R9: Any mode 11xx drives `pinOut` high while the 10-bit count {timerVal[7:0], 2-bit sub-count} is below the duty {data[7:0], control[5:4]}; the sub-count restarts at 0 whenever `timerVal` changes, so with the timer stepping every 4 clocks `pinOut` is high for exactly duty clocks of each 1024.
- R10: A new duty value takes effect only at the next period start (count 0); the running period keeps the old value.
- R11: Modes 0000, 0001 and 0011 disable the unit: no captures, no compare actions, `pinOut` low, and the output latch is cleared so re-entering a compare mode starts from low.
- R12: `intFlag` stays set until `flagClear` is pulsed; a new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 control, 1 data low, 2 data high) |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address, same map |
| rdData | output | 8 | Combinational read data |
| timerVal | input | 16 | Current value of the external timer |
| capPin | input | 1 | Asynchronous capture input |
| flagClear | input | 1 | Clears the interrupt flag |
| pinOut | output | 1 | Compare / PWM output pin |
| intFlag | output | 1 | Sticky interrupt flag |
| specialOut | output | 1 | One-cycle special-event strobe |

## Verification
The assertions assume that the timer never presents the same value on two separate runs without a different value in between, so a match is a single event, and that the capture pin holds each level for at least three clocks so the synchroniser sees every edge. The stimulus keeps the timer steady around each capture pulse, moves it away after every forced match, and holds each pin level for four clocks. For PWM the timer advances exactly every four clocks, which makes one period exactly 1024 clocks and lets duty be measured as a count of high cycles.

// File: rtl/cap_cmp_pwm_pkg.sv
package cap_cmp_pwm_pkg;

  typedef enum logic [2:0] {
    MK_OFF,
    MK_CAP,
    MK_CMP_TGL,
    MK_CMP_HI,
    MK_CMP_LO,
    MK_CMP_SOFT,
    MK_CMP_EVT,
    MK_PWM
  } modeKind_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;    // copy the timer into the data register
    logic cmpHit;     // first cycle of a compare match in a compare mode
    logic enterMode;  // mode code changed in the previous cycle
    logic clearAll;   // unit is disabled
  } strobes_t;

  function automatic modeKind_t decodeMode(input logic [3:0] code);
    modeKind_t k;
    casez (code)
      4'b0010: k = MK_CMP_TGL;
      4'b01??: k = MK_CAP;
      4'b1000: k = MK_CMP_HI;
      4'b1001: k = MK_CMP_LO;
      4'b1010: k = MK_CMP_SOFT;
      4'b1011: k = MK_CMP_EVT;
      4'b11??: k = MK_PWM;
      default: k = MK_OFF;
    endcase
    return k;
  endfunction

  function automatic logic isCompare(input modeKind_t k);
    return (k == MK_CMP_TGL) || (k == MK_CMP_HI) || (k == MK_CMP_LO) ||
           (k == MK_CMP_SOFT) || (k == MK_CMP_EVT);
  endfunction

endpackage

// File: rtl/cap_cmp_pwm_ctrl.sv
module cap_cmp_pwm_ctrl
  import cap_cmp_pwm_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int EXT_W      = 2,
  parameter int PRESC_FAST = 4,
  parameter int PRESC_SLOW = 16,
  localparam int DATA_W    = 2 * BUS_W,
  localparam int PRESC_W   = $clog2(PRESC_SLOW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [1:0]        rdAddr,
  output logic [BUS_W-1:0]  rdData,
  input  logic              capPin,
  input  logic              cmpEqual,
  input  logic [DATA_W-1:0] dataReg,
  output strobes_t          strobes,
  output modeKind_t         modeKind,
  output logic [EXT_W-1:0]  dutyLsb
);

  localparam logic [3:0] CODE_FALL  = 4'b0100;
  localparam logic [3:0] CODE_RISE  = 4'b0101;
  localparam logic [3:0] CODE_QUART = 4'b0110;
  localparam logic [3:0] CODE_SIXT  = 4'b0111;

  logic [3:0]         modeCode;
  logic [EXT_W-1:0]   dutyLsbReg;
  logic               enterReg;
  logic [2:0]         syncQ;
  logic [PRESC_W-1:0] presc;
  logic               matchPrev;
  logic               ctrlWr, modeChange, rise, fall, prescMode, prescWrap;
  logic [PRESC_W-1:0] prescLimit;

  assign ctrlWr     = wrEn && (wrAddr == 2'd0);
  assign modeChange = ctrlWr && (wrData[3:0] != modeCode);
  assign modeKind   = decodeMode(modeCode);
  assign dutyLsb    = dutyLsbReg;

  assign rise = syncQ[1] && !syncQ[2];
  assign fall = !syncQ[1] && syncQ[2];

  assign prescMode  = (modeCode == CODE_QUART) || (modeCode == CODE_SIXT);
  assign prescLimit = (modeCode == CODE_SIXT) ? PRESC_W'(PRESC_SLOW - 1)
                                              : PRESC_W'(PRESC_FAST - 1);
  assign prescWrap  = (presc == prescLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeCode   <= '0;
      dutyLsbReg <= '0;
      enterReg   <= 1'b0;
      syncQ      <= '0;
      presc      <= '0;
      matchPrev  <= 1'b0;
    end else begin
      if (ctrlWr) begin
        modeCode   <= wrData[3:0];
        dutyLsbReg <= wrData[4 +: EXT_W];
      end
      enterReg  <= modeChange;
      syncQ     <= {syncQ[1:0], capPin};
      matchPrev <= cmpEqual;
      if (modeKind == MK_OFF || modeChange) begin
        presc <= '0;
      end else if (rise && prescMode) begin
        presc <= prescWrap ? '0 : presc + 1'b1;
      end
    end
  end

  always_comb begin
    strobes = '0;
    strobes.enterMode = enterReg;
    strobes.clearAll  = (modeKind == MK_OFF);
    strobes.cmpHit    = isCompare(modeKind) && cmpEqual && !matchPrev;
    unique case (modeCode)
      CODE_FALL:  strobes.capture = fall;
      CODE_RISE:  strobes.capture = rise;
      CODE_QUART,
      CODE_SIXT:  strobes.capture = rise && prescWrap;
      default:    strobes.capture = 1'b0;
    endcase
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      2'd0: begin
        rdData[3:0]        = modeCode;
        rdData[4 +: EXT_W] = dutyLsbReg;
      end
      2'd1:    rdData = dataReg[BUS_W-1:0];
      2'd2:    rdData = dataReg[DATA_W-1:BUS_W];
      default: rdData = '0;
    endcase
  end

  AST_PRESC_QUARTER: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == CODE_QUART) |-> (presc < PRESC_W'(PRESC_FAST))); // R4

  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cmpHit |=> !strobes.cmpHit); // R5

  AST_OFF_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (modeKind == MK_OFF) |-> !strobes.capture && !strobes.cmpHit); // R11

endmodule

// File: rtl/cap_cmp_pwm_dp.sv
module cap_cmp_pwm_dp
  import cap_cmp_pwm_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int EXT_W   = 2,
  localparam int DATA_W = 2 * BUS_W,
  localparam int DUTY_W = BUS_W + EXT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  modeKind_t         modeKind,
  input  logic [EXT_W-1:0]  dutyLsb,
  input  logic [DATA_W-1:0] timerVal,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              flagClear,
  output logic [DATA_W-1:0] dataReg,
  output logic              cmpEqual,
  output logic              pinOut,
  output logic              intFlag,
  output logic              specialOut
);

  logic              pinLatch, pwmLevel;
  logic [DATA_W-1:0] timerPrev;
  logic [EXT_W-1:0]  subReg, subNext;
  logic [DUTY_W-1:0] pwmCount, dutyNew, dutyActive, dutyUse;
  logic              timerMoved, periodStart;

  assign cmpEqual = (timerVal == dataReg);

  // PWM count: timer low byte extended by a sub-count that restarts on each timer step
  assign timerMoved  = (timerVal != timerPrev);
  assign subNext     = timerMoved ? '0 : ((&subReg) ? subReg : subReg + 1'b1);
  assign pwmCount    = {timerVal[BUS_W-1:0], subNext};
  assign dutyNew     = {dataReg[BUS_W-1:0], dutyLsb};
  assign periodStart = (pwmCount == '0);
  assign dutyUse     = periodStart ? dutyNew : dutyActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg    <= '0;
      pinLatch   <= 1'b0;
      intFlag    <= 1'b0;
      specialOut <= 1'b0;
      timerPrev  <= '0;
      subReg     <= '0;
      dutyActive <= '0;
      pwmLevel   <= 1'b0;
    end else begin
      if (strobes.capture) begin
        dataReg <= timerVal;
      end else if (wrEn && wrAddr == 2'd1) begin
        dataReg[BUS_W-1:0] <= wrData;
      end else if (wrEn && wrAddr == 2'd2) begin
        dataReg[DATA_W-1:BUS_W] <= wrData;
      end

      if (strobes.clearAll) begin
        pinLatch <= 1'b0;
      end else begin
        if (strobes.enterMode && modeKind == MK_CMP_HI) pinLatch <= 1'b0;
        if (strobes.enterMode && modeKind == MK_CMP_LO) pinLatch <= 1'b1;
        if (strobes.cmpHit) begin
          unique case (modeKind)
            MK_CMP_TGL: pinLatch <= ~pinLatch;
            MK_CMP_HI:  pinLatch <= 1'b1;
            MK_CMP_LO:  pinLatch <= 1'b0;
            default:    pinLatch <= pinLatch;
          endcase
        end
      end

      if (strobes.capture || strobes.cmpHit) intFlag <= 1'b1;
      else if (flagClear)                    intFlag <= 1'b0;

      specialOut <= strobes.cmpHit && (modeKind == MK_CMP_EVT);

      timerPrev <= timerVal;
      subReg    <= subNext;
      if (periodStart) dutyActive <= dutyNew;
      pwmLevel  <= (modeKind == MK_PWM) && (pwmCount < dutyUse);
    end
  end

  always_comb begin
    unique case (modeKind)
      MK_PWM:                                   pinOut = pwmLevel;
      MK_CMP_TGL, MK_CMP_HI, MK_CMP_LO,
      MK_CMP_SOFT, MK_CMP_EVT:                  pinOut = pinLatch;
      default:                                  pinOut = 1'b0;
    endcase
  end

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (dataReg == $past(timerVal)) && intFlag); // R3

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cmpHit && modeKind == MK_CMP_TGL) |=> (pinLatch != $past(pinLatch))); // R5

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cmpHit && modeKind == MK_CMP_HI) |=> pinLatch); // R6

  AST_SOFT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cmpHit && modeKind == MK_CMP_SOFT && !strobes.enterMode) |=> $stable(pinLatch)); // R7

  AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    specialOut |=> !specialOut); // R8

  AST_EVENT_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    specialOut |-> intFlag); // R8

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (pwmCount != '0) |=> $stable(dutyActive)); // R10

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> !pinLatch); // R11

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !flagClear) |=> intFlag); // R12

endmodule

// File: rtl/cap_cmp_pwm.sv
module cap_cmp_pwm
  import cap_cmp_pwm_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int EXT_W   = 2,
  localparam int DATA_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [1:0]        rdAddr,
  output logic [BUS_W-1:0]  rdData,
  input  logic [DATA_W-1:0] timerVal,
  input  logic              capPin,
  input  logic              flagClear,
  output logic              pinOut,
  output logic              intFlag,
  output logic              specialOut
);

  strobes_t          strobes;
  modeKind_t         modeKind;
  logic [EXT_W-1:0]  dutyLsb;
  logic [DATA_W-1:0] dataReg;
  logic              cmpEqual;

  cap_cmp_pwm_ctrl #(.BUS_W(BUS_W), .EXT_W(EXT_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .capPin   (capPin),
    .cmpEqual (cmpEqual),
    .dataReg  (dataReg),
    .strobes  (strobes),
    .modeKind (modeKind),
    .dutyLsb  (dutyLsb)
  );

  cap_cmp_pwm_dp #(.BUS_W(BUS_W), .EXT_W(EXT_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .modeKind   (modeKind),
    .dutyLsb    (dutyLsb),
    .timerVal   (timerVal),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .flagClear  (flagClear),
    .dataReg    (dataReg),
    .cmpEqual   (cmpEqual),
    .pinOut     (pinOut),
    .intFlag    (intFlag),
    .specialOut (specialOut)
  );

endmodule

// File: tb/test_cap_cmp_pwm.sv
module test_cap_cmp_pwm;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic [15:0] timerVal;
  logic        capPin = 1'b0;
  logic        flagClear = 1'b0;
  logic        pinOut, intFlag, specialOut;

  logic        timerRun = 1'b0;
  logic [15:0] manualTmr = '0;
  logic [15:0] autoTmr = '0;
  logic [1:0]  div = '0;
  logic        scoreOn = 1'b0;

  int checks = 0;
  int fails = 0;
  int specialSeen = 0;
  int highSeen = 0;
  logic [15:0] expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  assign timerVal = timerRun ? autoTmr : manualTmr;

  cap_cmp_pwm i_cap_cmp_pwm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .timerVal(timerVal), .capPin(capPin),
    .flagClear(flagClear), .pinOut(pinOut), .intFlag(intFlag), .specialOut(specialOut)
  );

  // free-running timer: one step every 4 clocks
  always @(negedge clk) begin
    if (!timerRun) begin
      autoTmr <= '0;
      div     <= '0;
    end else begin
      div <= div + 2'd1;
      if (div == 2'd3) autoTmr <= autoTmr + 16'd1;
    end
  end

  always @(negedge clk) begin
    if (specialOut) specialSeen++;
    if (pinOut)     highSeen++;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearFlag();
    @(negedge clk);
    flagClear = 1'b1;
    @(negedge clk);
    flagClear = 1'b0;
  endtask

  // driver: one pin pulse with the timer held; expected capture pushed when due
  task automatic pulse(input logic [15:0] v, input bit expectCap);
    @(negedge clk);
    manualTmr = v;
    if (expectCap) expQ.push_back(v);
    capPin = 1'b1;
    waitClk(4);
    capPin = 1'b0;
    waitClk(4);
  endtask

  task automatic forceMatch(input logic [15:0] v);
    @(negedge clk);
    manualTmr = v;
    waitClk(3);
    manualTmr = 16'h0000;
    waitClk(2);
  endtask

  // monitor: pops one expected capture per flag and compares the data register
  initial begin
    logic [7:0] lo, hi;
    forever begin
      @(negedge clk);
      if (scoreOn && intFlag) begin
        readReg(2'd1, lo);
        readReg(2'd2, hi);
        if (expQ.size() == 0) begin
          check("R4 unexpected capture", {hi, lo}, 0);
        end else begin
          check("R3 captured timer value", {hi, lo}, expQ.pop_front());
        end
        flagClear = 1'b1;
        @(negedge clk);
        flagClear = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    int snap;
    waitClk(3);
    rstN = 1'b1;
    waitClk(1);

    // R1 reset state
    readReg(2'd0, d); check("R1 control after reset", d, 0);
    readReg(2'd1, d); check("R1 data low after reset", d, 0);
    readReg(2'd2, d); check("R1 data high after reset", d, 0);
    check("R1 pin after reset", pinOut, 0);
    check("R1 flag after reset", intFlag, 0);
    check("R1 special after reset", specialOut, 0);

    // R2 control field layout
    writeReg(2'd0, 8'hF0);
    readReg(2'd0, d); check("R2 top bits read zero", d, 8'h30);
    writeReg(2'd0, 8'h00);

    // R3 rising then falling capture
    scoreOn = 1'b1;
    writeReg(2'd0, 8'h05);
    pulse(16'h1111, 1);
    pulse(16'h2222, 1);
    writeReg(2'd0, 8'h04);
    pulse(16'h3333, 1);
    waitClk(4);

    // R4 prescaled capture
    writeReg(2'd0, 8'h06);
    for (int i = 1; i <= 7; i++) pulse(16'h4000 + 16'(i), i == 4);
    waitClk(4);
    writeReg(2'd0, 8'h07);
    for (int i = 1; i <= 16; i++) pulse(16'h5000 + 16'(i), i == 16);
    waitClk(6);
    check("R4 pending captures", expQ.size(), 0);
    scoreOn = 1'b0;
    waitClk(2);

    // R11 reserved code disables capture
    writeReg(2'd0, 8'h01);
    pulse(16'h6666, 0);
    check("R11 reserved mode no capture flag", intFlag, 0);
    readReg(2'd2, d); check("R11 reserved mode data kept", d, 8'h50);

    // compare set-up
    writeReg(2'd0, 8'h00);
    manualTmr = 16'h0000;
    writeReg(2'd1, 8'h34);
    writeReg(2'd2, 8'h12);

    // R5 toggle
    writeReg(2'd0, 8'h02);
    forceMatch(16'h1234);
    check("R5 toggle first match pin", pinOut, 1);
    check("R5 toggle flag", intFlag, 1);
    clearFlag();
    check("R12 flag cleared", intFlag, 0);
    forceMatch(16'h1234);
    check("R5 toggle second match pin", pinOut, 0);
    clearFlag();
    forceMatch(16'h1234);
    check("R5 toggle third match pin", pinOut, 1);
    clearFlag();

    // R7 flag only, level held
    writeReg(2'd0, 8'h0A);
    forceMatch(16'h1234);
    check("R7 soft mode flag", intFlag, 1);
    check("R7 soft mode pin unchanged", pinOut, 1);
    clearFlag();

    // R11 disable clears the latch
    writeReg(2'd0, 8'h00);
    waitClk(1);
    check("R11 disabled pin", pinOut, 0);
    writeReg(2'd0, 8'h02);
    waitClk(2);
    check("R11 latch cleared on re-entry", pinOut, 0);

    // R6 force high / force low
    writeReg(2'd0, 8'h08);
    waitClk(2);
    check("R6 init low", pinOut, 0);
    forceMatch(16'h1234);
    check("R6 forced high", pinOut, 1);
    check("R6 flag on force high", intFlag, 1);
    clearFlag();
    writeReg(2'd0, 8'h09);
    waitClk(2);
    check("R6 init high", pinOut, 1);
    forceMatch(16'h1234);
    check("R6 forced low", pinOut, 0);
    clearFlag();

    // R8 special event
    writeReg(2'd0, 8'h0B);
    snap = specialSeen;
    forceMatch(16'h1234);
    waitClk(2);
    check("R8 special strobe cycles", specialSeen - snap, 1);
    check("R8 special flag", intFlag, 1);
    clearFlag();

    // R11 reserved code ignores matches
    writeReg(2'd0, 8'h03);
    snap = specialSeen;
    forceMatch(16'h1234);
    check("R11 reserved mode no match flag", intFlag, 0);
    check("R11 reserved mode pin", pinOut, 0);
    check("R11 reserved mode no strobe", specialSeen - snap, 0);

    // R9 PWM duty windows
    writeReg(2'd0, 8'h00);
    writeReg(2'd1, 8'h00);
    timerRun = 1'b1;
    writeReg(2'd0, 8'h0C);
    waitClk(2100);
    snap = highSeen; waitClk(1024);
    check("R9 duty 0 high cycles", highSeen - snap, 0);

    writeReg(2'd1, 8'hFF);
    writeReg(2'd0, 8'h3C);
    waitClk(2100);
    snap = highSeen; waitClk(1024);
    check("R9 duty 1023 high cycles", highSeen - snap, 1023);

    writeReg(2'd1, 8'h4B);
    writeReg(2'd0, 8'h1F);
    waitClk(2100);
    snap = highSeen; waitClk(1024);
    check("R9 duty 301 high cycles", highSeen - snap, 301);

    // R10 duty change held until period start
    while (autoTmr[7:0] != 8'd128) @(negedge clk);
    writeReg(2'd1, 8'hE1);
    snap = highSeen;
    while (autoTmr[7:0] != 8'd0) @(negedge clk);
    check("R10 old duty kept in running period", highSeen - snap, 0);
    waitClk(2);
    snap = highSeen; waitClk(1024);
    check("R10 new duty 901 next period", highSeen - snap, 901);

    finishRun();
  end

endmodule